// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns register writes into software-generated interrupts (SGIs) exchanged among up to eight CPUs. A write to the generate register names an SGI number, a filter mode and, for one of the modes, an explicit list of target CPUs. For every CPU the filter selects, the block records the issuing CPU in a per-target, per-SGI source bitmap and marks that SGI pending for that target.

Two byte-addressable windows, one that sets source bits and one that clears them, give software direct access to the bitmaps of the CPU named on `req_cpu`. Both windows read back the current bitmaps. Each CPU has its own pending vector on `sgi_pend_o`, driven straight from flops. Priority arbitration, acknowledge and delivery to the CPUs are left to the blocks that consume these vectors.

Top module: `sgi_dispatch`

## Requirements
- R1: A synchronous reset clears every source bitmap, every pending flag and `bus_rdata`.
- R2: A write to the generate register (byte address 0x00) takes the SGI number from bits [3:0], the target list from bits [23:16] (bit 16+j names CPU j) and the filter mode from bits [25:24]. Mode 0 targets the listed CPUs. A listed CPU whose index is not below `cpus_online` is ignored. The byte enables do not affect this write.
- R3: Mode 1 targets every CPU whose index is below `cpus_online`, except the requesting CPU `req_cpu`.
- R4: Mode 2 targets only the requesting CPU.
- R5: A generate write in mode 3 changes no bitmap and no pending flag.
- R6: For each targeted CPU c, bit `req_cpu` is ORed into the bitmap of CPU c for that SGI, and `sgi_pend_o[c*16+sgi]` reads 1 after the clock edge that takes the write.
- R7: The clear window occupies byte addresses 0x10 to 0x1F and the set window occupies 0x20 to 0x2F. In either window, byte k holds the bitmap of SGI k for CPU `req_cpu`, and bit j of that byte stands for source CPU j. A read returns the word on `bus_rdata` in the cycle after `bus_rd_en`.
- R8: A write to the clear window clears the bitmap bits that are written as 1. The pending flag drops only when the bitmap becomes zero.
- R9: A write to the set window ORs the written bits into the bitmap. The SGI becomes pending only if the resulting bitmap is non-zero, so writing zero to an idle SGI leaves it idle.
- R10: On window writes, byte lane b (bits [8b+7:8b]) is written only when `bus_be[b]` is 1. Lanes that are not enabled leave their bitmaps unchanged.
- R11: A read of the generate register, or of any address outside the two windows, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for window writes |
| bus_rdata | output | 32 | Registered read data |
| req_cpu | input | $clog2(NUM_CPU) (3) | Index of the CPU making the access |
| cpus_online | input | $clog2(NUM_CPU+1) (4) | Number of CPUs online |
| sgi_pend_o | output | NUM_CPU*NUM_SGI (128) | Pending flags; bit c*NUM_SGI+s is SGI s for CPU c |

## Verification
The generate path is exercised in each filter mode with different requester positions and with online counts below eight. This separates a list mask that ignores offline CPUs from one that passes the list through unchanged, and it shows whether "all but self" really excludes the requester. Window writes use partial byte enables with non-zero data in the disabled lanes, which catches a lane decoder that ignores `bus_be`. Clears are done in two steps on a bitmap with two sources, so a pending flag that drops on the first partial clear is exposed. A set of zero on an idle SGI shows whether pending is raised without any source. A long random mix of all operations, checked against a reference model after every step, covers the interactions between them.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;
  typedef enum logic [1:0] {
    MODE_LIST   = 2'd0,
    MODE_OTHERS = 2'd1,
    MODE_SELF   = 2'd2,
    MODE_RSVD   = 2'd3
  } sgi_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_GEN  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_SET  = 2'd3
  } acc_kind_e;

  localparam int MODE_LSB = 24;
  localparam int LIST_LSB = 16;
endpackage

// File: rtl/sgi_bus_decode.sv
`timescale 1ns/1ps
module sgi_bus_decode
  import sgi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN_BYTES = 16,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h10,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h20,
  localparam int WORD_W = (WIN_BYTES > 4) ? $clog2(WIN_BYTES / 4) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [WORD_W-1:0] word_idx
);
  logic [ADDR_W-1:0] off_clr, off_set;
  logic in_clr, in_set;

  always_comb begin
    off_clr = addr - CLR_BASE;
    off_set = addr - SET_BASE;
    in_clr  = (addr >= CLR_BASE) && (off_clr < ADDR_W'(WIN_BYTES));
    in_set  = (addr >= SET_BASE) && (off_set < ADDR_W'(WIN_BYTES));
    kind     = ACC_NONE;
    word_idx = '0;
    if (addr == GEN_ADDR) begin
      kind = ACC_GEN;
    end else if (in_clr) begin
      kind     = ACC_CLR;
      word_idx = off_clr[2 +: WORD_W];
    end else if (in_set) begin
      kind     = ACC_SET;
      word_idx = off_set[2 +: WORD_W];
    end
  end
endmodule

// File: rtl/sgi_target_filter.sv
`timescale 1ns/1ps
module sgi_target_filter
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
  input  sgi_mode_e          mode,
  input  logic [NUM_CPU-1:0] list,
  input  logic [IDX_W-1:0]   req,
  input  logic [CNT_W-1:0]   online,
  output logic [NUM_CPU-1:0] targets,
  output logic [NUM_CPU-1:0] req_onehot
);
  logic [NUM_CPU-1:0] online_mask;

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      online_mask[i] = (CNT_W'(i) < online);
      req_onehot[i]  = (IDX_W'(i) == req);
    end
    unique case (mode)
      MODE_LIST:   targets = list & online_mask;
      MODE_OTHERS: targets = online_mask & ~req_onehot;
      MODE_SELF:   targets = req_onehot;
      default:     targets = '0;
    endcase
  end
endmodule

// File: rtl/sgi_pending_bank.sv
`timescale 1ns/1ps
module sgi_pending_bank #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int SGI_W = $clog2(NUM_SGI)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            gen_hit,
  input  logic [SGI_W-1:0]                gen_sgi,
  input  logic [NUM_CPU-1:0]              gen_src,
  input  logic [NUM_SGI-1:0]              win_en,
  input  logic                            win_set,
  input  logic [NUM_SGI-1:0][NUM_CPU-1:0] win_data,
  output logic [NUM_SGI-1:0][NUM_CPU-1:0] src_o,
  output logic [NUM_SGI-1:0]              pend_o
);
  for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
    logic [NUM_CPU-1:0] map_q, map_nxt;
    logic               pend_q;

    always_comb begin
      if (win_set) map_nxt = map_q | win_data[s];
      else         map_nxt = map_q & ~win_data[s];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        map_q  <= '0;
        pend_q <= 1'b0;
      end else if (gen_hit && (gen_sgi == SGI_W'(s))) begin
        map_q  <= map_q | gen_src;
        pend_q <= 1'b1;
      end else if (win_en[s]) begin
        map_q <= map_nxt;
        if (win_set) begin
          if (|map_nxt) pend_q <= 1'b1;
        end else if (map_nxt == '0) begin
          pend_q <= 1'b0;
        end
      end
    end

    assign src_o[s]  = map_q;
    assign pend_o[s] = pend_q;
  end
endmodule

// File: rtl/sgi_dispatch.sv
`timescale 1ns/1ps
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h10,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h20,
  localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W  = $clog2(NUM_CPU + 1),
  localparam int SGI_W  = $clog2(NUM_SGI),
  localparam int WORD_W = (NUM_SGI > 4) ? $clog2(NUM_SGI / 4) : 1,
  localparam int PEND_W = NUM_CPU * NUM_SGI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  req_cpu,
  input  logic [CNT_W-1:0]  cpus_online,
  output logic [PEND_W-1:0] sgi_pend_o
);
  acc_kind_e          kind;
  logic [WORD_W-1:0]  word_idx;
  logic [NUM_CPU-1:0] targets, req_onehot;
  logic               gen_fire, win_wr, win_set;
  logic [NUM_SGI-1:0] win_en;
  logic [NUM_SGI-1:0][NUM_CPU-1:0] win_data;
  logic [NUM_SGI-1:0][NUM_CPU-1:0] src_all [NUM_CPU];
  logic [PEND_W*NUM_CPU-1:0] src_flat;
  logic [31:0]        rd_word;

  sgi_bus_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(NUM_SGI),
    .GEN_ADDR(GEN_ADDR), .CLR_BASE(CLR_BASE), .SET_BASE(SET_BASE)
  ) dec_i (
    .addr(bus_addr), .kind(kind), .word_idx(word_idx)
  );

  sgi_target_filter #(.NUM_CPU(NUM_CPU)) filt_i (
    .mode      (sgi_mode_e'(bus_wdata[MODE_LSB +: 2])),
    .list      (bus_wdata[LIST_LSB +: NUM_CPU]),
    .req       (req_cpu),
    .online    (cpus_online),
    .targets   (targets),
    .req_onehot(req_onehot)
  );

  assign gen_fire = bus_wr_en && (kind == ACC_GEN);
  assign win_wr   = bus_wr_en && ((kind == ACC_CLR) || (kind == ACC_SET));
  assign win_set  = (kind == ACC_SET);

  for (genvar s = 0; s < NUM_SGI; s++) begin : g_lane
    assign win_en[s]   = win_wr && (word_idx == WORD_W'(s / 4)) && bus_be[s % 4];
    assign win_data[s] = bus_wdata[(s % 4) * 8 +: NUM_CPU];
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SGI-1:0] bank_en;
    assign bank_en = (req_cpu == IDX_W'(c)) ? win_en : '0;

    sgi_pending_bank #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .gen_hit (gen_fire && targets[c]),
      .gen_sgi (bus_wdata[SGI_W-1:0]),
      .gen_src (req_onehot),
      .win_en  (bank_en),
      .win_set (win_set),
      .win_data(win_data),
      .src_o   (src_all[c]),
      .pend_o  (sgi_pend_o[c*NUM_SGI +: NUM_SGI])
    );
    assign src_flat[c*NUM_SGI*NUM_CPU +: NUM_SGI*NUM_CPU] = src_all[c];
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < 4; b++) begin
      rd_word[b*8 +: 8] = 8'(src_all[req_cpu][{word_idx, 2'(b)}]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en && ((kind == ACC_CLR) || (kind == ACC_SET))) begin
      bus_rdata <= rd_word;
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
`timescale 1ns/1ps
module sgi_dispatch_chk #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h10,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h20,
  localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PEND_W = NUM_CPU * NUM_SGI,
  localparam int PIDX_W = $clog2(PEND_W)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr_en,
  input logic                      bus_rd_en,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [IDX_W-1:0]          req_cpu,
  input logic [PEND_W-1:0]         sgi_pend_o,
  input logic [PEND_W*NUM_CPU-1:0] src_flat
);
  logic gen_wr, in_window;
  logic [PIDX_W-1:0] self_idx;

  assign gen_wr    = bus_wr_en && (bus_addr == GEN_ADDR);
  assign in_window = ((bus_addr >= CLR_BASE) && (bus_addr < CLR_BASE + ADDR_W'(NUM_SGI))) ||
                     ((bus_addr >= SET_BASE) && (bus_addr < SET_BASE + ADDR_W'(NUM_SGI)));
  assign self_idx  = PIDX_W'(req_cpu) * PIDX_W'(NUM_SGI) + PIDX_W'(bus_wdata[$clog2(NUM_SGI)-1:0]);

  // R1: reset empties the pending outputs and read data
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sgi_pend_o == '0) && (bus_rdata == '0));

  // R4: a self-directed generate leaves the requester pending for that SGI
  assert_self_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (gen_wr && (bus_wdata[25:24] == 2'd2)) |=> sgi_pend_o[$past(self_idx)]);

  // R5: reserved mode leaves all state alone
  assert_rsvd_no_effect_R5: assert property (@(posedge clk) disable iff (rst)
    (gen_wr && (bus_wdata[25:24] == 2'd3)) |=> ($stable(src_flat) && $stable(sgi_pend_o)));

  // R11: reads outside the windows return zero
  assert_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !in_window) |=> (bus_rdata == '0));

  // R8 / R9: each pending flag tracks whether its bitmap holds any source
  for (genvar i = 0; i < PEND_W; i++) begin : g_track
    assert_pend_tracks_map_R8: assert property (@(posedge clk) disable iff (rst)
      sgi_pend_o[i] == (|src_flat[i*NUM_CPU +: NUM_CPU]));
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .ADDR_W(ADDR_W),
  .GEN_ADDR(GEN_ADDR), .CLR_BASE(CLR_BASE), .SET_BASE(SET_BASE)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .req_cpu(req_cpu), .sgi_pend_o(sgi_pend_o), .src_flat(src_flat)
);

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
  localparam int NC = 8;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  req_cpu = '0;
  logic [3:0]  cpus_online = 4'd8;
  logic [NC*NS-1:0] sgi_pend_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_src [NC][NS];

  always #5 clk = ~clk;

  sgi_dispatch dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .req_cpu(req_cpu), .cpus_online(cpus_online),
    .sgi_pend_o(sgi_pend_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NC*NS-1:0] exp_pend();
    logic [NC*NS-1:0] v;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) v[c*NS+s] = |m_src[c][s];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input int cpu);
    logic [31:0] v = '0;
    int w;
    if (a >= 8'h10 && a < 8'h30) begin
      w = (a >= 8'h20) ? int'(a - 8'h20) / 4 : int'(a - 8'h10) / 4;
      for (int b = 0; b < 4; b++) v[b*8 +: 8] = m_src[cpu][w*4+b];
    end
    return v;
  endfunction

  function automatic logic [7:0] tmask(input logic [31:0] d, input int req, input int online);
    logic [7:0] om = '0;
    for (int i = 0; i < NC; i++) om[i] = (i < online);
    case (d[25:24])
      2'd0: return d[23:16] & om;
      2'd1: return om & ~(8'd1 << req);
      2'd2: return 8'd1 << req;
      default: return 8'd0;
    endcase
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                          input int req, input int online);
    logic [7:0] tm;
    int w;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be;
    req_cpu = 3'(req); cpus_online = 4'(online); bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a == 8'h00) begin
      tm = tmask(d, req, online);
      for (int c = 0; c < NC; c++)
        if (tm[c]) m_src[c][d[3:0]] = m_src[c][d[3:0]] | (8'd1 << req);
    end else if (a >= 8'h10 && a < 8'h30) begin
      w = (a >= 8'h20) ? int'(a - 8'h20) / 4 : int'(a - 8'h10) / 4;
      for (int b = 0; b < 4; b++)
        if (be[b]) begin
          if (a >= 8'h20) m_src[req][w*4+b] = m_src[req][w*4+b] | d[b*8 +: 8];
          else            m_src[req][w*4+b] = m_src[req][w*4+b] & ~d[b*8 +: 8];
        end
    end
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input int cpu);
    @(negedge clk);
    bus_addr = a; req_cpu = 3'(cpu); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk(tag, 128'(bus_rdata), 128'(exp_rd(a, cpu)));
  endtask

  task automatic pend_check(input string tag);
    chk(tag, 128'(sgi_pend_o), 128'(exp_pend()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed1);
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) m_src[c][s] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    pend_check("R1 pend after reset");
    rd_check("R1 window after reset", 8'h10, 0);
    // R2 list mode, offline target bit 6 ignored
    do_write(8'h00, 32'h0045_0003, 4'h0, 1, 4);
    pend_check("R2 list mode");
    rd_check("R6 source bit of requester", 8'h10, 0);
    rd_check("R6 target 2 bitmap", 8'h20, 2);
    // R3 all but self
    do_write(8'h00, 32'h0100_0007, 4'hF, 2, 3);
    pend_check("R3 all but self");
    rd_check("R3 cpu1 bitmap", 8'h14, 1);
    // R4 self only
    do_write(8'h00, 32'h02FF_000F, 4'hF, 1, 8);
    pend_check("R4 self only");
    // R5 reserved mode
    do_write(8'h00, 32'h03FF_0005, 4'hF, 0, 8);
    pend_check("R5 reserved mode");
    rd_check("R5 cpu0 bitmaps unchanged", 8'h14, 0);
    // R10 lane select, R9 set
    do_write(8'h24, 32'h5A5A_815A, 4'h2, 3, 8);
    pend_check("R10 single lane set");
    rd_check("R10 lane readback", 8'h24, 3);
    do_write(8'h24, 32'h0000_0000, 4'h4, 3, 8);
    pend_check("R9 zero set keeps idle");
    // R8 partial then full clear
    do_write(8'h00, 32'h0200_0003, 4'hF, 0, 8);
    do_write(8'h10, 32'h0200_0000, 4'h8, 0, 8);
    pend_check("R8 partial clear keeps pending");
    rd_check("R8 remaining bitmap", 8'h10, 0);
    do_write(8'h10, 32'h0100_0000, 4'h8, 0, 8);
    pend_check("R8 full clear drops pending");
    // R7 both windows agree, R11 zero reads
    rd_check("R7 clear window read", 8'h14, 1);
    rd_check("R7 set window read", 8'h24, 1);
    rd_check("R11 generate reads zero", 8'h00, 1);
    rd_check("R11 unmapped reads zero", 8'h30, 1);

    for (int n = 0; n < 400; n++) begin
      int online, req, op;
      logic [7:0] a;
      logic [31:0] d;
      online = 1 + int'($urandom % 8);
      req    = int'($urandom % online);
      op     = int'($urandom % 6);
      d      = $urandom;
      if (op < 2) begin
        a = 8'h00;
      end else if (op < 4) begin
        a = 8'h20 + 8'(($urandom % 4) * 4);
      end else begin
        a = 8'h10 + 8'(($urandom % 4) * 4);
        d = d & $urandom;
      end
      do_write(a, d, 4'($urandom), req, online);
      pend_check("R6 R8 R9 random pend");
      if (n % 8 == 0) begin
        rd_check("R7 random window read", 8'h10 + 8'(($urandom % 8) * 4), int'($urandom % 8));
      end
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) m_src[c][s] = '0;
    pend_check("R1 second reset");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule